// File: doc/BRIEF.md
# Byte-Lane Synchronous RAM Port

This block is the control path and storage for a single clocked port of a static RAM. The RAM is 36 bits wide and is divided into four lanes of 9 bits each. On every rising clock edge the port samples a pair of opposite-polarity chip selects, four active-low lane enables and a read/write strobe. From these it writes the enabled lanes of the addressed word, or reads them. Read data leaves on a tri-state bus. Each lane has its own drive enable, and that enable is also brought out as a port.

Two inputs gate the bus without waiting for a clock: an output enable and a sleep request. Sleep also blocks any access that is sampled while it is high. A parameter sets the read latency. With flow-through, data for a read sampled at edge k is on the bus after edge k. With pipelined, it appears one edge later, and the lane enables are delayed by the same amount. Address generation lies outside this block. The address arrives already formed.

Top module: `lane_ram_port`

## Requirements
- R1: Lane i occupies bus bits i*9 to i*9+8, for lane 0 through lane 3. A write through lane 2 alone changes bits 18..26 of the stored word and no other bits.
- R2: The port is selected only when en_a_n is 0 and en_b is 1. With any other pair, no write takes place and no lane drives after the sampling edge.
- R3: lane_en_n bit i, when 0, enables lane i. Any subset of lanes can be written or read in one access. Lanes that are not enabled are neither written nor driven.
- R4: If the port is selected with all four lane enables at 1, the stored word does not change and lane_drive stays at 0.
- R5: rd_nwr=1 requests a read and rd_nwr=0 requests a write. A write cycle never causes any lane to drive.
- R6: out_en_n=1 holds every lane undriven. This gate acts without a clock. A read that is sampled while out_en_n is high still drives as soon as out_en_n falls within the same cycle.
- R7: sleep=1 holds every lane undriven at once, whatever the other inputs are. Once sleep falls, lanes that were driving before it rose drive again.
- R8: When sleep is 1 at a clock edge, no write takes place and no read is launched at that edge.
- R9: With PIPELINED=0, a read sampled at edge k drives its enabled lanes with the stored data from just after edge k until edge k+1.
- R10: With PIPELINED=1, a read sampled at edge k drives from just after edge k+1. The lane set is that read's own, even when a read with a different lane set follows directly behind it.
- R11: While rst is high and after it, lane_drive is 0 until a read is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the read control pipeline |
| addr | input | ADDR_W | Word address |
| en_a_n | input | 1 | Active-low chip select |
| en_b | input | 1 | Active-high chip select |
| lane_en_n | input | LANES | Active-low per-lane enables |
| rd_nwr | input | 1 | 1 = read, 0 = write |
| out_en_n | input | 1 | Asynchronous active-low bus output enable |
| sleep | input | 1 | Asynchronous sleep; forces the bus undriven and blocks access |
| wdata | input | LANES*LANE_W | Write data |
| lane_drive | output | LANES | Per-lane bus drive enable |
| bus_q | output | LANES*LANE_W | Tri-state read data bus |

## Verification
The bench runs a flow-through instance and a pipelined instance side by side on the same stimulus. It issues two reads back to back with disjoint lane sets. A pipelined variant that delays the data but not the lane enables would then show the first read's data on the second read's lanes.

The bench also tries to write to the port while it is deselected, while all enables are high, and while sleep is high, and each time reads the word back. A decode that lets any of these writes through leaves a corrupted word. The bench toggles out_en_n and sleep in the middle of a cycle. An output gate that was registered rather than combinational would miss those edges.

One partial-lane write touches lane 2 only. A lane slice that was off by one or swapped would show up in the bits read back.

// File: rtl/lane_ram_pkg.sv
package lane_ram_pkg;

  typedef enum logic {
    LAT_FLOW = 1'b0,
    LAT_PIPE = 1'b1
  } lat_e;

  function automatic logic port_sel(input logic a_n, input logic b);
    return !a_n && b;
  endfunction

endpackage

// File: rtl/lane_decode.sv
module lane_decode
  import lane_ram_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             en_a_n,
  input  logic             en_b,
  input  logic [LANES-1:0] lane_en_n,
  input  logic             rd_nwr,
  input  logic             sleep,
  output logic [LANES-1:0] wr_stb,
  output logic [LANES-1:0] rd_req
);

  logic live;

  assign live   = port_sel(en_a_n, en_b) && !sleep;
  assign wr_stb = {LANES{live && !rd_nwr}} & ~lane_en_n;
  assign rd_req = {LANES{live &&  rd_nwr}} & ~lane_en_n;

endmodule

// File: rtl/lane_mem.sv
module lane_mem #(
  parameter int W      = 9,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end

endmodule

// File: rtl/lane_out_stage.sv
module lane_out_stage
  import lane_ram_pkg::*;
#(
  parameter int LANES     = 4,
  parameter int LANE_W    = 9,
  parameter bit PIPELINED = 1'b0
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [LANES-1:0]        rd_req,
  input  logic [LANES*LANE_W-1:0] rdata,
  input  logic                    out_en_n,
  input  logic                    sleep,
  output logic [LANES-1:0]        lane_drive,
  output logic [LANES*LANE_W-1:0] bus_q
);

  localparam lat_e LAT   = PIPELINED ? LAT_PIPE : LAT_FLOW;
  localparam int   BUS_W = LANES * LANE_W;

  logic [LANES-1:0] rd_s1;
  logic [LANES-1:0] en_final;
  logic [BUS_W-1:0] data_final;

  always_ff @(posedge clk) begin
    if (rst) rd_s1 <= '0;
    else     rd_s1 <= rd_req;
  end

  generate
    if (LAT == LAT_PIPE) begin : g_pipe
      logic [LANES-1:0] rd_s2;
      logic [BUS_W-1:0] data_s2;
      always_ff @(posedge clk) begin
        if (rst) begin
          rd_s2   <= '0;
          data_s2 <= '0;
        end else begin
          rd_s2   <= rd_s1;
          data_s2 <= rdata;
        end
      end
      assign en_final   = rd_s2;
      assign data_final = data_s2;
    end else begin : g_flow
      assign en_final   = rd_s1;
      assign data_final = rdata;
    end
  endgenerate

  assign lane_drive = en_final & {LANES{!out_en_n && !sleep}};

  for (genvar i = 0; i < LANES; i++) begin : g_bus
    assign bus_q[i*LANE_W +: LANE_W] =
      lane_drive[i] ? data_final[i*LANE_W +: LANE_W] : {LANE_W{1'bz}};
  end

endmodule

// File: rtl/lane_ram_port.sv
module lane_ram_port
  import lane_ram_pkg::*;
#(
  parameter int LANES     = 4,
  parameter int LANE_W    = 9,
  parameter int ADDR_W    = 8,
  parameter bit PIPELINED = 1'b0,
  localparam int BUS_W    = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              en_a_n,
  input  logic              en_b,
  input  logic [LANES-1:0]  lane_en_n,
  input  logic              rd_nwr,
  input  logic              out_en_n,
  input  logic              sleep,
  input  logic [BUS_W-1:0]  wdata,
  output logic [LANES-1:0]  lane_drive,
  output logic [BUS_W-1:0]  bus_q
);

  logic [LANES-1:0] wr_stb;
  logic [LANES-1:0] rd_req;
  logic [BUS_W-1:0] rdata;

  lane_decode #(.LANES(LANES)) u_dec (
    .en_a_n   (en_a_n),
    .en_b     (en_b),
    .lane_en_n(lane_en_n),
    .rd_nwr   (rd_nwr),
    .sleep    (sleep),
    .wr_stb   (wr_stb),
    .rd_req   (rd_req)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    lane_mem #(.W(LANE_W), .ADDR_W(ADDR_W)) u_mem (
      .clk  (clk),
      .we   (wr_stb[i]),
      .addr (addr),
      .wdata(wdata[i*LANE_W +: LANE_W]),
      .rdata(rdata[i*LANE_W +: LANE_W])
    );
  end

  lane_out_stage #(.LANES(LANES), .LANE_W(LANE_W), .PIPELINED(PIPELINED)) u_out (
    .clk       (clk),
    .rst       (rst),
    .rd_req    (rd_req),
    .rdata     (rdata),
    .out_en_n  (out_en_n),
    .sleep     (sleep),
    .lane_drive(lane_drive),
    .bus_q     (bus_q)
  );

  // R7
  sleep_hiz_chk: assert property (@(posedge clk) disable iff (rst)
    sleep |-> lane_drive == '0);

  // R6
  oe_hiz_chk: assert property (@(posedge clk) disable iff (rst)
    out_en_n |-> lane_drive == '0);

  generate
    if (PIPELINED) begin : g_chk_pipe
      // R2
      desel_pipe_chk: assert property (@(posedge clk) disable iff (rst)
        !port_sel(en_a_n, en_b) |=> ##1 lane_drive == '0);
      // R5
      write_pipe_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_nwr |=> ##1 lane_drive == '0);
      // R10
      lane_pipe_chk: assert property (@(posedge clk) disable iff (rst)
        (lane_drive & $past(lane_en_n, 2)) == '0);
    end else begin : g_chk_flow
      // R2
      desel_flow_chk: assert property (@(posedge clk) disable iff (rst)
        !port_sel(en_a_n, en_b) |=> lane_drive == '0);
      // R5
      write_flow_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_nwr |=> lane_drive == '0);
      // R3
      lane_flow_chk: assert property (@(posedge clk) disable iff (rst)
        (lane_drive & $past(lane_en_n)) == '0);
    end
  endgenerate

endmodule

// File: tb/lane_ram_port_test.sv
module lane_ram_port_test;

  localparam int CLK_PERIOD = 10;
  localparam int LANES  = 4;
  localparam int LANE_W = 9;
  localparam int ADDR_W = 8;
  localparam int BUS_W  = LANES * LANE_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic en_a_n = 1'b1;
  logic en_b = 1'b1;
  logic [LANES-1:0] lane_en_n = '1;
  logic rd_nwr = 1'b1;
  logic out_en_n = 1'b0;
  logic sleep = 1'b0;
  logic [BUS_W-1:0] wdata = '0;
  logic [LANES-1:0] drv_f, drv_p;
  logic [BUS_W-1:0] q_f, q_p;

  int total = 0;
  int bad = 0;
  logic [BUS_W-1:0] shadow [1 << ADDR_W];

  always #(CLK_PERIOD/2) clk = ~clk;

  lane_ram_port #(.LANES(LANES), .LANE_W(LANE_W), .ADDR_W(ADDR_W), .PIPELINED(1'b0)) uut (
    .clk(clk), .rst(rst), .addr(addr), .en_a_n(en_a_n), .en_b(en_b),
    .lane_en_n(lane_en_n), .rd_nwr(rd_nwr), .out_en_n(out_en_n), .sleep(sleep),
    .wdata(wdata), .lane_drive(drv_f), .bus_q(q_f));

  lane_ram_port #(.LANES(LANES), .LANE_W(LANE_W), .ADDR_W(ADDR_W), .PIPELINED(1'b1)) uut_pipe (
    .clk(clk), .rst(rst), .addr(addr), .en_a_n(en_a_n), .en_b(en_b),
    .lane_en_n(lane_en_n), .rd_nwr(rd_nwr), .out_en_n(out_en_n), .sleep(sleep),
    .wdata(wdata), .lane_drive(drv_p), .bus_q(q_p));

  function automatic logic [BUS_W-1:0] lane_bits(input logic [LANES-1:0] m);
    logic [BUS_W-1:0] r;
    for (int i = 0; i < LANES; i++) r[i*LANE_W +: LANE_W] = {LANE_W{m[i]}};
    return r;
  endfunction

  task automatic chk(input string tag, input logic [LANES-1:0] dg, input logic [BUS_W-1:0] qg,
                     input logic [LANES-1:0] me, input logic [BUS_W-1:0] de);
    logic [BUS_W-1:0] m;
    m = lane_bits(me);
    total++;
    if (dg !== me || ((qg ^ de) & m) !== '0) begin
      bad++;
      $display("FAIL %s: drive=%b data=%h expected drive=%b data=%h",
               tag, dg, qg & m, me, de & m);
    end
  endtask

  task automatic cyc(input logic a_n, input logic b, input logic [LANES-1:0] be,
                     input logic rw, input logic [ADDR_W-1:0] a, input logic [BUS_W-1:0] d);
    @(negedge clk);
    en_a_n = a_n; en_b = b; lane_en_n = be; rd_nwr = rw; addr = a; wdata = d;
    @(posedge clk);
    if (!a_n && b && !sleep && !rw)
      for (int i = 0; i < LANES; i++)
        if (!be[i]) shadow[a][i*LANE_W +: LANE_W] = d[i*LANE_W +: LANE_W];
    #1;
  endtask

  task automatic idle();
    cyc(1'b1, 1'b1, '1, 1'b1, '0, '0);
  endtask

  task automatic rd(input string tag, input logic [ADDR_W-1:0] a, input logic [LANES-1:0] be);
    cyc(1'b0, 1'b1, be, 1'b1, a, '0);
    chk({tag, " flow"}, drv_f, q_f, ~be, shadow[a]);
    idle();
    chk({tag, " pipe"}, drv_p, q_p, ~be, shadow[a]);
    chk({tag, " flow released"}, drv_f, q_f, '0, '0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R11 in reset flow", drv_f, q_f, '0, '0);
    chk("R11 in reset pipe", drv_p, q_p, '0, '0);
    @(negedge clk); rst = 1'b0;
    idle();
    chk("R11 after reset flow", drv_f, q_f, '0, '0);
    chk("R11 after reset pipe", drv_p, q_p, '0, '0);
  endtask

  task automatic t_init();
    cyc(1'b0, 1'b1, 4'b0000, 1'b0, 8'd2, 36'hA_5A5A_5A5A);
    cyc(1'b0, 1'b1, 4'b0000, 1'b0, 8'd3, 36'h3_1234_5678);
    cyc(1'b0, 1'b1, 4'b0000, 1'b0, 8'd4, 36'hC_8765_4321);
    cyc(1'b0, 1'b1, 4'b0000, 1'b0, 8'd5, 36'h5_0F0F_0F0F);
  endtask

  task automatic t_lane_map();
    cyc(1'b0, 1'b1, 4'b0000, 1'b0, 8'd1, 36'h0);
    cyc(1'b0, 1'b1, 4'b1011, 1'b0, 8'd1, 36'hF_FFFF_FFFF);
    cyc(1'b0, 1'b1, 4'b0000, 1'b1, 8'd1, '0);
    chk("R1 lane 2 bits 18..26", drv_f, q_f, 4'b1111, 36'h0_07FC_0000);
    idle();
  endtask

  task automatic t_lane_mix();
    cyc(1'b0, 1'b1, 4'b0101, 1'b0, 8'd2, 36'h0);
    rd("R3 full word after partial write", 8'd2, 4'b0000);
    rd("R3 lanes 0,2", 8'd2, 4'b1010);
    rd("R3 lanes 0,3", 8'd4, 4'b0110);
  endtask

  task automatic t_no_lanes();
    cyc(1'b0, 1'b1, 4'b1111, 1'b0, 8'd3, 36'hF_FFFF_FFFF);
    rd("R4 word kept", 8'd3, 4'b0000);
    cyc(1'b0, 1'b1, 4'b1111, 1'b1, 8'd3, '0);
    chk("R4 no lane driven", drv_f, q_f, '0, '0);
    idle();
    chk("R4 no lane driven pipe", drv_p, q_p, '0, '0);
  endtask

  task automatic t_deselect();
    cyc(1'b1, 1'b1, 4'b0000, 1'b0, 8'd5, 36'h0);
    cyc(1'b0, 1'b0, 4'b0000, 1'b0, 8'd5, 36'h0);
    cyc(1'b1, 1'b0, 4'b0000, 1'b0, 8'd5, 36'h0);
    rd("R2 R8 word kept when deselected", 8'd5, 4'b0000);
    cyc(1'b0, 1'b0, 4'b0000, 1'b1, 8'd5, '0);
    chk("R2 deselected read flow", drv_f, q_f, '0, '0);
    cyc(1'b1, 1'b1, 4'b0000, 1'b1, 8'd5, '0);
    chk("R2 deselected read flow 2", drv_f, q_f, '0, '0);
    chk("R2 deselected read pipe", drv_p, q_p, '0, '0);
  endtask

  task automatic t_write_quiet();
    idle();
    cyc(1'b0, 1'b1, 4'b0000, 1'b0, 8'd4, 36'h1_2222_3333);
    chk("R5 write cycle flow", drv_f, q_f, '0, '0);
    idle();
    chk("R5 write cycle pipe", drv_p, q_p, '0, '0);
    rd("R5 write landed", 8'd4, 4'b0000);
  endtask

  task automatic t_back_to_back();
    idle();
    cyc(1'b0, 1'b1, 4'b1100, 1'b1, 8'd2, '0);
    chk("R9 first read flow", drv_f, q_f, 4'b0011, shadow[2]);
    chk("R10 first read not yet on pipe", drv_p, q_p, '0, '0);
    cyc(1'b0, 1'b1, 4'b0011, 1'b1, 8'd3, '0);
    chk("R9 second read flow", drv_f, q_f, 4'b1100, shadow[3]);
    chk("R10 first read on pipe", drv_p, q_p, 4'b0011, shadow[2]);
    idle();
    chk("R10 second read on pipe", drv_p, q_p, 4'b1100, shadow[3]);
    chk("R9 flow released", drv_f, q_f, '0, '0);
  endtask

  task automatic t_out_enable();
    out_en_n = 1'b1;
    cyc(1'b0, 1'b1, 4'b0000, 1'b1, 8'd3, '0);
    chk("R6 held off flow", drv_f, q_f, '0, '0);
    out_en_n = 1'b0; #1;
    chk("R6 released mid cycle flow", drv_f, q_f, 4'b1111, shadow[3]);
    out_en_n = 1'b1;
    idle();
    chk("R6 held off pipe", drv_p, q_p, '0, '0);
    out_en_n = 1'b0; #1;
    chk("R6 released mid cycle pipe", drv_p, q_p, 4'b1111, shadow[3]);
    idle();
  endtask

  task automatic t_sleep();
    cyc(1'b0, 1'b1, 4'b0000, 1'b1, 8'd4, '0);
    sleep = 1'b1; #1;
    chk("R7 sleep blanks flow", drv_f, q_f, '0, '0);
    sleep = 1'b0; #1;
    chk("R7 wake restores flow", drv_f, q_f, 4'b1111, shadow[4]);
    idle();
    sleep = 1'b1; #1;
    chk("R7 sleep blanks pipe", drv_p, q_p, '0, '0);
    cyc(1'b0, 1'b1, 4'b0000, 1'b0, 8'd4, 36'h0);
    cyc(1'b0, 1'b1, 4'b0000, 1'b1, 8'd4, '0);
    sleep = 1'b0; #1;
    chk("R8 no read launched in sleep", drv_f, q_f, '0, '0);
    idle();
    chk("R8 no read launched in sleep pipe", drv_p, q_p, '0, '0);
    rd("R8 no write in sleep", 8'd4, 4'b0000);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    total++;
    bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_init();
    t_lane_map();
    t_lane_mix();
    t_no_lanes();
    t_deselect();
    t_write_quiet();
    t_back_to_back();
    t_out_enable();
    t_sleep();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule